// File: doc/BRIEF.md
# Logic-Array-Block Carry Chain with Half-Block Exit

This block routes the arithmetic carry through one logic array block built from eight arithmetic elements, each holding two bits of the chain. The adder logic is abstracted: every bit offers a propagate and a generate input, and the block returns a sum bit per position (propagate XOR incoming carry), the carry leaving the block, and a tap showing the carry entering each element.

One configuration pin chooses the chain length. In full mode the carry ripples through all eight elements and leaves from the last one. In half mode only the lower four elements carry arithmetic. The carry leaving the fourth element goes straight to the block's carry output. The upper four elements each see a carry input of 0, so they are free for unrelated logic.

Blocks are cascaded by wiring one block's carry output to the next block's carry input. A mixed chain therefore has an active width of 16 or 8 bits per block. The block is purely combinational. It carries no stream traffic, so it has no valid/ready handshake and every pin is a plain level.

Top module: `lab_carry_chain`

## Requirements
- R1: The carry into bit i is `gen[i-1] | (prop[i-1] & carry into bit i-1)`, and `sum[i] = prop[i] ^ carry into bit i`. With `prop = a ^ b` and `gen = a & b`, full mode (`cfg_half_exit` = 0) gives `sum` = low 16 bits of a + b + `carry_in`. With all inputs 0, every output is 0.
- R2: In full mode, `carry_out` equals bit 16 of a + b + `carry_in`.
- R3: In half mode (`cfg_half_exit` = 1), `elem_cin[7:4]` are all 0.
- R4: `elem_cin[0]` always equals `carry_in`.
- R5: In full mode, `elem_cin[k]` (k = 1..7) is the carry into bit 2k, i.e. bit 2k of (a mod 2^2k) + (b mod 2^2k) + `carry_in`.
- R6: In half mode, `sum[7:0]` equals the low 8 bits of a[7:0] + b[7:0] + `carry_in`, and `carry_out` equals bit 8 of that sum.
- R7: In half mode, for each upper element k = 4..7: `sum[2k] = prop[2k]` and `sum[2k+1] = prop[2k+1] ^ gen[2k]`.
- R8: In half mode, `carry_out` depends only on `carry_in`, `prop[7:0]` and `gen[7:0]`. Bits 15:8 have no effect on it.
- R9: Three cascaded blocks in any mix of modes produce sums and a final carry equal to an adder whose width is the sum of the active widths (16 in full mode, 8 in half mode, taken from the low bits of each block).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_half_exit | input | 1 | 0: chain passes all eight elements; 1: chain leaves after element 4 |
| carry_in | input | 1 | Carry from the previous block |
| prop | input | 16 | Per-bit propagate terms |
| gen | input | 16 | Per-bit generate terms |
| sum | output | 16 | Per-bit sum (propagate XOR incoming carry) |
| carry_out | output | 1 | Carry to the next block |
| elem_cin | output | 8 | Carry entering each element |

## Verification
The bound checker watches the structural relations at every input change. These are: the first tap follows `carry_in`; each tap follows the ripple from the one below it; the upper taps are held at 0 in half mode; every sum bit matches its propagate and incoming carry; and the carry output is taken from the element the mode selects. Those relations alone do not show that the chain adds correctly. Only the bench's sweeps can show that. It compares against arithmetic sums of real operands in both modes. It shows that the upper operand bits never affect the carry output in half mode. It also checks that three cascaded blocks in all eight mode mixes add as one adder of the combined active width.

// File: rtl/lab_carry_pkg.sv
package lab_carry_pkg;

  typedef enum logic {
    CHAIN_FULL = 1'b0,
    CHAIN_HALF = 1'b1
  } chain_mode_e;

  function automatic logic carry_step(input logic p, input logic g, input logic c);
    return g | (p & c);
  endfunction

endpackage

// File: rtl/carry_elem.sv
module carry_elem
  import lab_carry_pkg::*;
#(
  parameter int unsigned ELEM_BITS = 2
) (
  input  logic [ELEM_BITS-1:0] p_i,
  input  logic [ELEM_BITS-1:0] g_i,
  input  logic                 cin_i,
  output logic [ELEM_BITS-1:0] sum_o,
  output logic                 cout_o
);

  logic [ELEM_BITS:0] c_w;

  assign c_w[0] = cin_i;

  for (genvar b = 0; b < ELEM_BITS; b++) begin : g_bit
    assign c_w[b+1]  = carry_step(p_i[b], g_i[b], c_w[b]);
    assign sum_o[b]  = p_i[b] ^ c_w[b];
  end

  assign cout_o = c_w[ELEM_BITS];

endmodule

// File: rtl/carry_link.sv
module carry_link
  import lab_carry_pkg::*;
#(
  parameter int unsigned LAB_ELEMS = 8,
  parameter int unsigned EXIT_AT   = LAB_ELEMS / 2
) (
  input  chain_mode_e          mode_i,
  input  logic                 blk_cin_i,
  input  logic [LAB_ELEMS-1:0] elem_cout_i,
  output logic [LAB_ELEMS-1:0] elem_cin_o,
  output logic                 blk_cout_o
);

  for (genvar k = 0; k < LAB_ELEMS; k++) begin : g_link
    if (k == 0) begin : g_first
      assign elem_cin_o[k] = blk_cin_i;
    end else if (k < EXIT_AT) begin : g_lower
      assign elem_cin_o[k] = elem_cout_i[k-1];
    end else begin : g_upper
      assign elem_cin_o[k] = (mode_i == CHAIN_HALF) ? 1'b0 : elem_cout_i[k-1];
    end
  end

  assign blk_cout_o = (mode_i == CHAIN_HALF) ? elem_cout_i[EXIT_AT-1]
                                             : elem_cout_i[LAB_ELEMS-1];

endmodule

// File: rtl/lab_carry_chain.sv
module lab_carry_chain
  import lab_carry_pkg::*;
#(
  parameter int unsigned LAB_ELEMS = 8,
  parameter int unsigned ELEM_BITS = 2,
  localparam int unsigned WIDTH    = LAB_ELEMS * ELEM_BITS
) (
  input  logic                 cfg_half_exit,
  input  logic                 carry_in,
  input  logic [WIDTH-1:0]     prop,
  input  logic [WIDTH-1:0]     gen,
  output logic [WIDTH-1:0]     sum,
  output logic                 carry_out,
  output logic [LAB_ELEMS-1:0] elem_cin
);

  localparam int unsigned EXIT_AT = LAB_ELEMS / 2;

  chain_mode_e          mode_w;
  logic [LAB_ELEMS-1:0] elem_cout_w;

  assign mode_w = chain_mode_e'(cfg_half_exit);

  for (genvar k = 0; k < LAB_ELEMS; k++) begin : g_elem
    carry_elem #(.ELEM_BITS(ELEM_BITS)) u_elem (
      .p_i   (prop[k*ELEM_BITS +: ELEM_BITS]),
      .g_i   (gen[k*ELEM_BITS +: ELEM_BITS]),
      .cin_i (elem_cin[k]),
      .sum_o (sum[k*ELEM_BITS +: ELEM_BITS]),
      .cout_o(elem_cout_w[k])
    );
  end

  carry_link #(.LAB_ELEMS(LAB_ELEMS), .EXIT_AT(EXIT_AT)) u_link (
    .mode_i     (mode_w),
    .blk_cin_i  (carry_in),
    .elem_cout_i(elem_cout_w),
    .elem_cin_o (elem_cin),
    .blk_cout_o (carry_out)
  );

endmodule

// File: rtl/lab_carry_chain_chk.sv
module lab_carry_chain_chk #(
  parameter int unsigned LAB_ELEMS = 8,
  parameter int unsigned ELEM_BITS = 2,
  localparam int unsigned WIDTH    = LAB_ELEMS * ELEM_BITS
) (
  input logic                 cfg_half_exit,
  input logic                 carry_in,
  input logic [WIDTH-1:0]     prop,
  input logic [WIDTH-1:0]     gen,
  input logic [WIDTH-1:0]     sum,
  input logic                 carry_out,
  input logic [LAB_ELEMS-1:0] elem_cin
);

  localparam int unsigned EXIT_AT = LAB_ELEMS / 2;

  // carry leaving element k, rippled from its observed tap
  function automatic logic out_of(input int k, input logic [WIDTH-1:0] p,
                                  input logic [WIDTH-1:0] g, input logic [LAB_ELEMS-1:0] t);
    logic c;
    c = t[k];
    for (int b = 0; b < ELEM_BITS; b++) c = g[k*ELEM_BITS+b] | (p[k*ELEM_BITS+b] & c);
    return c;
  endfunction

  function automatic logic into_bit(input int i, input logic [WIDTH-1:0] p,
                                    input logic [WIDTH-1:0] g, input logic [LAB_ELEMS-1:0] t);
    logic c;
    int   k;
    k = i / ELEM_BITS;
    c = t[k];
    for (int b = k*ELEM_BITS; b < i; b++) c = g[b] | (p[b] & c);
    return c;
  endfunction

  always_comb begin
    p_tap0_r4: assert (elem_cin[0] == carry_in)
      else $error("first tap differs from carry_in");
    for (int k = 1; k < LAB_ELEMS; k++) begin
      if (cfg_half_exit && k >= EXIT_AT) begin
        p_upper_zero_r3: assert (elem_cin[k] == 1'b0)
          else $error("upper tap %0d not held low", k);
      end else begin
        p_link_r5: assert (elem_cin[k] == out_of(k-1, prop, gen, elem_cin))
          else $error("tap %0d breaks ripple", k);
      end
    end
    for (int i = 0; i < WIDTH; i++) begin
      p_sum_r1: assert (sum[i] == (prop[i] ^ into_bit(i, prop, gen, elem_cin)))
        else $error("sum bit %0d inconsistent", i);
    end
    p_cout_sel_r2: assert (carry_out == (cfg_half_exit ? out_of(EXIT_AT-1, prop, gen, elem_cin)
                                                        : out_of(LAB_ELEMS-1, prop, gen, elem_cin)))
      else $error("carry_out taken from wrong element");
  end

endmodule

bind lab_carry_chain lab_carry_chain_chk #(
  .LAB_ELEMS(LAB_ELEMS),
  .ELEM_BITS(ELEM_BITS)
) u_chk (
  .cfg_half_exit(cfg_half_exit),
  .carry_in     (carry_in),
  .prop         (prop),
  .gen          (gen),
  .sum          (sum),
  .carry_out    (carry_out),
  .elem_cin     (elem_cin)
);

// File: tb/lab_carry_chain_bench.sv
module lab_carry_chain_bench;

  localparam int CLK_NS = 4;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // single block under test
  logic        mode, cin, cout;
  logic [15:0] a, b, s;
  logic [7:0]  taps;

  lab_carry_chain u_lab_carry_chain (
    .cfg_half_exit(mode), .carry_in(cin), .prop(a ^ b), .gen(a & b),
    .sum(s), .carry_out(cout), .elem_cin(taps)
  );

  // three cascaded blocks
  logic [2:0]  cm;
  logic        c_cin;
  logic [15:0] ca [3];
  logic [15:0] cb [3];
  logic [15:0] cs [3];
  logic [2:0]  cco;
  logic [7:0]  ctap [3];

  for (genvar i = 0; i < 3; i++) begin : g_blk
    lab_carry_chain u_blk (
      .cfg_half_exit(cm[i]),
      .carry_in     (i == 0 ? c_cin : cco[(i == 0) ? 0 : i-1]),
      .prop         (ca[i] ^ cb[i]),
      .gen          (ca[i] & cb[i]),
      .sum          (cs[i]),
      .carry_out    (cco[i]),
      .elem_cin     (ctap[i])
    );
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic apply_single(input logic m, input logic [15:0] av,
                              input logic [15:0] bv, input logic ci);
    logic [16:0] full;
    logic [8:0]  half;
    logic [15:0] p, g;
    logic [7:0]  up;
    mode = m; a = av; b = bv; cin = ci;
    #(CLK_NS/2);
    p = av ^ bv; g = av & bv;
    check("R4", "first tap", 64'(taps[0]), 64'(ci));
    if (!m) begin
      full = {1'b0, av} + {1'b0, bv} + 17'(ci);
      check("R1", "full sum", 64'(s), 64'(full[15:0]));
      check("R2", "full carry_out", 64'(cout), 64'(full[16]));
      for (int k = 1; k < 8; k++) begin
        logic [16:0] lo;
        logic [15:0] msk;
        msk = (16'h1 << (2*k)) - 16'h1;
        lo  = {1'b0, av & msk} + {1'b0, bv & msk} + 17'(ci);
        check("R5", "tap", 64'(taps[k]), 64'(lo[2*k]));
      end
    end else begin
      half = {1'b0, av[7:0]} + {1'b0, bv[7:0]} + 9'(ci);
      check("R6", "half low sum", 64'(s[7:0]), 64'(half[7:0]));
      check("R6", "half carry_out", 64'(cout), 64'(half[8]));
      check("R3", "upper taps", 64'(taps[7:4]), 64'(0));
      for (int k = 4; k < 8; k++) begin
        up[2*(k-4)]   = p[2*k];
        up[2*(k-4)+1] = p[2*k+1] ^ g[2*k];
      end
      check("R7", "upper sums", 64'(s[15:8]), 64'(up));
    end
    #(CLK_NS/2);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin : main
    logic [15:0] hi;
    mode = 1'b0; cin = 1'b0; a = '0; b = '0;
    cm = '0; c_cin = 1'b0;
    for (int i = 0; i < 3; i++) begin ca[i] = '0; cb[i] = '0; end
    #1;
    // idle state: zero in, zero out (R1)
    check("R1", "idle sum", 64'(s), 64'(0));
    check("R1", "idle carry_out", 64'(cout), 64'(0));
    check("R1", "idle taps", 64'(taps), 64'(0));
    #(CLK_NS-1);

    // corner cases
    apply_single(1'b0, 16'hFFFF, 16'h0000, 1'b1);
    apply_single(1'b0, 16'hFFFF, 16'hFFFF, 1'b1);
    apply_single(1'b0, 16'h8000, 16'h8000, 1'b0);
    apply_single(1'b1, 16'h00FF, 16'h0000, 1'b1);
    apply_single(1'b1, 16'hFFFF, 16'hFFFF, 1'b1);
    apply_single(1'b1, 16'h0F80, 16'h0080, 1'b0);

    // full mode: pseudo-random sweep
    for (int n = 0; n < 3000; n++)
      apply_single(1'b0, 16'($urandom), 16'($urandom), 1'($urandom));

    // half mode: all low a, spread of low b, random upper bits (R8)
    for (int av = 0; av < 256; av++)
      for (int bv = 0; bv < 256; bv += 17)
        for (int ci = 0; ci < 2; ci++)
          apply_single(1'b1, {8'($urandom), 8'(av)}, {8'($urandom), 8'(bv)}, 1'(ci));

    // R8: upper bits swept with fixed low operands, carry_out unchanged
    for (int n = 0; n < 64; n++) begin
      hi = 16'($urandom);
      mode = 1'b1; a = {hi[15:8], 8'hFF}; b = {hi[7:0], 8'h00}; cin = 1'b1;
      #(CLK_NS/2);
      check("R8", "half carry_out vs upper bits", 64'(cout), 64'(1));
      #(CLK_NS/2);
      a = {hi[7:0], 8'h7F}; b = {hi[15:8], 8'h00}; cin = 1'b0;
      #(CLK_NS/2);
      check("R8", "half carry_out vs upper bits", 64'(cout), 64'(0));
      #(CLK_NS/2);
    end

    // R9: three blocks, every mode mix
    for (int m = 0; m < 8; m++) begin
      for (int n = 0; n < 200; n++) begin
        logic [63:0] ra, rb, tot, act;
        int pos;
        cm = 3'(m); c_cin = 1'($urandom);
        for (int i = 0; i < 3; i++) begin
          ca[i] = (n == 0) ? 16'hFFFF : 16'($urandom);
          cb[i] = (n == 0) ? 16'h0000 : 16'($urandom);
        end
        if (n == 0) c_cin = 1'b1;
        #(CLK_NS/2);
        ra = '0; rb = '0; act = '0; pos = 0;
        for (int i = 0; i < 3; i++) begin
          int w;
          logic [63:0] msk;
          w   = cm[i] ? 8 : 16;
          msk = (64'h1 << w) - 64'h1;
          ra  |= (64'(ca[i]) & msk) << pos;
          rb  |= (64'(cb[i]) & msk) << pos;
          act |= (64'(cs[i]) & msk) << pos;
          pos += w;
        end
        tot = ra + rb + 64'(c_cin);
        check("R9", "cascade sum", act, tot & ((64'h1 << pos) - 64'h1));
        check("R9", "cascade carry_out", 64'(cco[2]), 64'(tot[pos]));
        #(CLK_NS/2);
      end
    end

    done = 1'b1;
    report();
  end

endmodule